// File: doc/BRIEF.md
# Board Interrupt Aggregator with Slot Status

This block collects sixteen level-sensitive interrupt lines from board peripherals and reduces them to a single interrupt request for a host processor. Each source has an enable bit. A source that is high while its enable bit is set latches a pending bit. The request output is high whenever some pending bit is also enabled. Software acknowledges an interrupt by writing the whole pending word back with the bits it wants to keep. It does not use write-one-to-clear.

Two card slots have status/control words. A card-detect flag in each word is driven by one of the interrupt lines and is active low. The words also carry a constant ready flag and five host-writable control bits. Eight further words are plain read/write storage, and a read-only word shows the source levels captured on the previous clock.

The host port is synchronous, with an 8-bit byte address, a write strobe and 32-bit data. Read data is combinational from the address. Reset is asynchronous and active low, and the block releases it internally in step with the clock.

Top module: `irq_gather_regs`

## Requirements
- R1: While reset is held and after it is released, irq_out is low. The enable word, the pending word and all storage words read 0x00000000, and both slot words read 0x00000420.
- R2: A write to the enable word (offset 0xC0) stores bus_wdata AND 0x000FEEFF. The masked-out bits 8, 12 and 20–31 always read zero.
- R3: If source i is high at a clock edge and enable bit i is set, pending bit i reads 1 after that edge. A disabled source never sets its pending bit. A falling source does not clear its pending bit.
- R4: irq_out is high exactly when (pending AND enable) is nonzero. It reflects a write to either word from the cycle after that write.
- R5: A write to the pending word (offset 0xD0) replaces it with bus_wdata AND 0x000FEEFF, and this takes priority over any source in that cycle. An enabled source that stays high sets its bit again on the next edge.
- R6: Slot 0 (offset 0xE0) and slot 1 (offset 0xE4) hold an active-low detect flag at bit 5. It reads 0 on the cycle after source 9 (slot 0) or source 13 (slot 1) is high, and 1 otherwise. Bit 10 always reads 1.
- R7: A write to a slot word changes only bits 4:0. Every other bit of that word is unaffected.
- R8: Offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 are independent 32-bit read/write storage words.
- R9: Every other offset reads 0x00000000, including unaligned ones, and a write to it changes no register. The level word at 0xF0 ignores writes.
- R10: The level word at offset 0xF0 reads, in bits 15:0, the source inputs sampled at the most recent clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_src | input | 16 | Level interrupt sources 0 to 15 |
| irq_out | output | 1 | Aggregated interrupt request to the host |

## Verification
The bench steps a single source through all sixteen positions with enables on and then off. This catches a design that latches disabled sources, clears pending bits when a source falls, or ignores the hole at sources 8 and 12 in the keep mask. It clears a held-high enabled source and reads the pending word twice. A design that gives the source priority over the write would never show the cleared zero, and a design that only latches on an edge would not show the bit come back. It then writes every unmapped aligned word offset, two unaligned addresses and the level word. An address decoder that aliases would corrupt a slot, storage, enable or pending word, or return nonzero data. It also writes all ones to a slot word, which exposes a design that lets the ready or detect flags be overwritten.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
  localparam int NUM_SRC   = 16;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int NUM_STORE = 8;
  localparam int NUM_SLOT  = 2;
  localparam int SLOT_CTL_W   = 5;
  localparam int SLOT_DET_BIT = 5;
  localparam int SLOT_RDY_BIT = 10;
  localparam logic [DATA_W-1:0] PEND_KEEP = 32'h000F_EEFF;

  localparam logic [ADDR_W-1:0] OFF_ENA  = 8'hC0;
  localparam logic [ADDR_W-1:0] OFF_PEND = 8'hD0;
  localparam logic [ADDR_W-1:0] OFF_LVL  = 8'hF0;

  function automatic logic [ADDR_W-1:0] store_off(input int idx);
    case (idx)
      0:       return 8'h10;
      1:       return 8'h14;
      2:       return 8'h40;
      3:       return 8'h60;
      4:       return 8'h80;
      5:       return 8'h84;
      6:       return 8'h88;
      default: return 8'h90;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] slot_off(input int idx);
    return (idx == 0) ? 8'hE0 : 8'hE4;
  endfunction

  function automatic int slot_src(input int idx);
    return (idx == 0) ? 9 : 13;
  endfunction
endpackage

// File: rtl/irqg_rst_sync.sv
module irqg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_s_n = out_q;
endmodule

// File: rtl/irqg_pending.sv
module irqg_pending #(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 32,
  parameter logic [DATA_W-1:0] KEEP = 32'h000F_EEFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ena_we,
  input  logic               pend_we,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] src,
  output logic [DATA_W-1:0]  ena_q,
  output logic [DATA_W-1:0]  pend_q,
  output logic [NUM_SRC-1:0] lvl_q,
  output logic               irq_out
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [DATA_W-1:0]  src_ext;
  logic [DATA_W-1:0]  ena_d;
  logic [DATA_W-1:0]  pend_d;
  logic [NUM_SRC-1:0] lvl_d;

  assign src_ext = {{PAD_W{1'b0}}, src};

  always_comb begin
    ena_d  = ena_q;
    pend_d = pend_q | (src_ext & ena_q);
    lvl_d  = src;
    if (ena_we)  ena_d  = wdata & KEEP;
    if (pend_we) pend_d = wdata & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= '0;
      pend_q <= '0;
      lvl_q  <= '0;
    end else begin
      ena_q  <= ena_d;
      pend_q <= pend_d;
      lvl_q  <= lvl_d;
    end
  end

  assign irq_out = |(pend_q & ena_q);
endmodule

// File: rtl/irqg_slot.sv
module irqg_slot #(
  parameter int DATA_W  = 32,
  parameter int CTL_W   = 5,
  parameter int DET_BIT = 5,
  parameter int RDY_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTL_W-1:0]  wctl,
  input  logic              det_src,
  output logic [DATA_W-1:0] rd_val,
  output logic              det_n
);
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             det_q, det_d;

  always_comb begin
    ctl_d = ctl_q;
    if (we) ctl_d = wctl;
    det_d = ~det_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      det_q <= 1'b1;
    end else begin
      ctl_q <= ctl_d;
      det_q <= det_d;
    end
  end

  always_comb begin
    rd_val             = '0;
    rd_val[CTL_W-1:0]  = ctl_q;
    rd_val[DET_BIT]    = det_q;
    rd_val[RDY_BIT]    = 1'b1;
  end

  assign det_n = det_q;
endmodule

// File: rtl/irqg_store.sv
module irqg_store #(
  parameter int DATA_W = 32,
  parameter int NUM    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM-1:0]              we,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NUM-1:0][DATA_W-1:0]  rd_val
);
  for (genvar g = 0; g < NUM; g++) begin : g_word
    logic [DATA_W-1:0] word_q, word_d;

    always_comb begin
      word_d = word_q;
      if (we[g]) word_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign rd_val[g] = word_q;
  end
endmodule

// File: rtl/irq_gather_regs.sv
module irq_gather_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [15:0] irq_src,
  output logic        irq_out
);
  import irqg_pkg::*;

  localparam int LVL_PAD = DATA_W - NUM_SRC;

  logic rst_s_n;
  logic [DATA_W-1:0]  ena_q, pend_q;
  logic [NUM_SRC-1:0] lvl_q;
  logic [NUM_SLOT-1:0] slot_det_n;
  logic [NUM_SLOT-1:0] slot_we;
  logic [NUM_SLOT-1:0][DATA_W-1:0] slot_rd;
  logic [NUM_STORE-1:0] store_we;
  logic [NUM_STORE-1:0] store_hit;
  logic [NUM_STORE-1:0][DATA_W-1:0] store_rd;

  irqg_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  irqg_pending #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .KEEP    (PEND_KEEP)
  ) u_pend (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .ena_we  (bus_wr && (bus_addr == OFF_ENA)),
    .pend_we (bus_wr && (bus_addr == OFF_PEND)),
    .wdata   (bus_wdata),
    .src     (irq_src),
    .ena_q   (ena_q),
    .pend_q  (pend_q),
    .lvl_q   (lvl_q),
    .irq_out (irq_out)
  );

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
    assign slot_we[k] = bus_wr && (bus_addr == slot_off(k));
    irqg_slot #(
      .DATA_W  (DATA_W),
      .CTL_W   (SLOT_CTL_W),
      .DET_BIT (SLOT_DET_BIT),
      .RDY_BIT (SLOT_RDY_BIT)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .we      (slot_we[k]),
      .wctl    (bus_wdata[SLOT_CTL_W-1:0]),
      .det_src (irq_src[slot_src(k)]),
      .rd_val  (slot_rd[k]),
      .det_n   (slot_det_n[k])
    );
  end

  for (genvar s = 0; s < NUM_STORE; s++) begin : g_hit
    assign store_hit[s] = (bus_addr == store_off(s));
    assign store_we[s]  = bus_wr && store_hit[s];
  end

  irqg_store #(
    .DATA_W (DATA_W),
    .NUM    (NUM_STORE)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .we     (store_we),
    .wdata  (bus_wdata),
    .rd_val (store_rd)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFF_ENA)  bus_rdata = ena_q;
    if (bus_addr == OFF_PEND) bus_rdata = pend_q;
    if (bus_addr == OFF_LVL)  bus_rdata = {{LVL_PAD{1'b0}}, lvl_q};
    for (int k = 0; k < NUM_SLOT; k++) begin
      if (bus_addr == slot_off(k)) bus_rdata = slot_rd[k];
    end
    for (int s = 0; s < NUM_STORE; s++) begin
      if (store_hit[s]) bus_rdata = store_rd[s];
    end
  end
endmodule

// File: rtl/irqg_chk.sv
module irqg_chk (
  input logic        clk,
  input logic        rst_s_n,
  input logic [7:0]  bus_addr,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic [15:0] irq_src,
  input logic        irq_out,
  input logic [31:0] ena_q,
  input logic [31:0] pend_q,
  input logic [1:0]  slot_det_n
);
  import irqg_pkg::*;

  logic        w_ena, w_pend;
  logic [31:0] src_ext;

  assign w_ena   = bus_wr && (bus_addr == OFF_ENA);
  assign w_pend  = bus_wr && (bus_addr == OFF_PEND);
  assign src_ext = {16'h0000, irq_src};

  // R1
  always_comb begin
    if (!rst_s_n) begin
      reset_quiet_chk: assert (!irq_out);
    end
  end

  // R2
  ena_keep_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    w_ena |=> (ena_q == ($past(bus_wdata) & PEND_KEEP)));

  // R5
  pend_over_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    w_pend |=> (pend_q == ($past(bus_wdata) & PEND_KEEP)));

  // R3
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !w_pend |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R3
  src_raise_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!w_pend && !w_ena && ((src_ext & ena_q) != 32'h0)) |=> irq_out);

  // R4
  ena_off_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (w_ena && (bus_wdata == 32'h0)) |=> !irq_out);

  // R6
  det0_low_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_src[9] |=> !slot_det_n[0]);

  // R6
  det1_high_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !irq_src[13] |=> slot_det_n[1]);
endmodule

bind irq_gather_regs irqg_chk u_chk (
  .clk        (clk),
  .rst_s_n    (rst_s_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .irq_src    (irq_src),
  .irq_out    (irq_out),
  .ena_q      (ena_q),
  .pend_q     (pend_q),
  .slot_det_n (slot_det_n)
);

// File: tb/irq_gather_regs_tb.sv
`timescale 1ns/1ps
module irq_gather_regs_tb;
  localparam logic [31:0] KEEP = 32'h000F_EEFF;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] irq_src;
  logic        irq_out;

  int n_cmp  = 0;
  int n_fail = 0;

  irq_gather_regs u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_src   (irq_src),
    .irq_out   (irq_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] sto(input int i);
    case (i)
      0: return 8'h10; 1: return 8'h14; 2: return 8'h40; 3: return 8'h60;
      4: return 8'h80; 5: return 8'h84; 6: return 8'h88; default: return 8'h90;
    endcase
  endfunction

  function automatic bit mapped(input logic [7:0] a);
    for (int i = 0; i < 8; i++) if (a == sto(i)) return 1'b1;
    return (a == 8'hC0) || (a == 8'hD0) || (a == 8'hE0) || (a == 8'hE4) || (a == 8'hF0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pat [4];
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; irq_src = '0;
    repeat (3) tick();
    chk("R1 irq_out in reset", {31'h0, irq_out}, 32'h0);
    rst_n = 1'b1;
    repeat (3) tick();
    // R1 reset values
    chk("R1 irq_out", {31'h0, irq_out}, 32'h0);
    rchk("R1 enable", 8'hC0, 32'h0);
    rchk("R1 pending", 8'hD0, 32'h0);
    rchk("R1 slot0", 8'hE0, 32'h420);
    rchk("R1 slot1", 8'hE4, 32'h420);
    for (int i = 0; i < 8; i++) rchk("R1 storage", sto(i), 32'h0);

    // R2 enable and pending keep mask
    pat[0] = 32'hFFFF_FFFF; pat[1] = 32'hA5A5_A5A5; pat[2] = 32'h0000_1100; pat[3] = 32'h0;
    for (int p = 0; p < 4; p++) begin
      wr(8'hC0, pat[p]);
      rchk("R2 enable mask", 8'hC0, pat[p] & KEEP);
    end
    for (int p = 0; p < 4; p++) begin
      wr(8'hD0, pat[p]);
      rchk("R2 pending mask", 8'hD0, pat[p] & KEEP);
    end

    // R3 / R6 single source sweep
    for (int i = 0; i < 16; i++) begin
      logic [31:0] bit_i;
      bit_i = 32'h1 << i;
      wr(8'hC0, 32'hFFFF_FFFF);
      wr(8'hD0, 32'h0);
      irq_src = 16'(bit_i);
      tick();
      rchk("R6 slot0 detect", 8'hE0, (i == 9) ? 32'h400 : 32'h420);
      rchk("R6 slot1 detect", 8'hE4, (i == 13) ? 32'h400 : 32'h420);
      irq_src = '0;
      tick();
      rchk("R3 pending latched, kept after fall", 8'hD0, bit_i & KEEP);
      chk("R4 irq_out from source", {31'h0, irq_out}, {31'h0, |(bit_i & KEEP)});
      rchk("R6 slot0 released", 8'hE0, 32'h420);
      wr(8'hC0, 32'h0);
      wr(8'hD0, 32'h0);
      irq_src = 16'(bit_i);
      tick(); tick();
      rchk("R3 disabled source ignored", 8'hD0, 32'h0);
      irq_src = '0;
    end

    // R4 output versus pending AND enable
    tick();
    for (int b = 0; b < 20; b++) begin
      wr(8'hC0, 32'h0);
      wr(8'hD0, 32'h1 << b);
      chk("R4 pending without enable", {31'h0, irq_out}, 32'h0);
      wr(8'hC0, 32'h1 << b);
      chk("R4 pending with enable", {31'h0, irq_out}, {31'h0, KEEP[b]});
      wr(8'hD0, 32'h0);
      chk("R4 cleared", {31'h0, irq_out}, 32'h0);
    end

    // R5 overwrite priority and level re-set
    wr(8'hC0, 32'h8);
    irq_src = 16'h0008;
    tick();
    rchk("R5 held source set", 8'hD0, 32'h8);
    wr(8'hD0, 32'h0);
    rchk("R5 write wins its cycle", 8'hD0, 32'h0);
    chk("R5 irq_out after clear", {31'h0, irq_out}, 32'h0);
    tick();
    rchk("R5 held source sets again", 8'hD0, 32'h8);
    chk("R5 irq_out again", {31'h0, irq_out}, 32'h1);
    irq_src = '0;
    tick();
    wr(8'hD0, 32'h30);
    rchk("R5 overwrite drops old bit", 8'hD0, 32'h30);
    chk("R5 irq_out masked off", {31'h0, irq_out}, 32'h0);

    // R10 level word
    pat[0] = 32'hA5C3; pat[1] = 32'h0001; pat[2] = 32'hFFFF; pat[3] = 32'h8000;
    wr(8'hC0, 32'h0);
    for (int p = 0; p < 4; p++) begin
      irq_src = 16'(pat[p]);
      tick();
      rchk("R10 level word", 8'hF0, pat[p]);
    end
    irq_src = '0;
    tick();

    // R7 slot write masking
    wr(8'hE0, 32'hFFFF_FFFF);
    rchk("R7 slot0 all ones", 8'hE0, 32'h43F);
    wr(8'hE4, 32'hFFFF_FFE0);
    rchk("R7 slot1 high bits only", 8'hE4, 32'h420);
    wr(8'hE4, 32'h15);
    rchk("R7 slot1 control", 8'hE4, 32'h435);
    irq_src = 16'h0200;
    tick();
    rchk("R7 slot0 control kept with detect", 8'hE0, 32'h41F);
    irq_src = '0;
    tick();

    // R8 storage
    for (int i = 0; i < 8; i++) wr(sto(i), 32'hC0DE_0000 | (32'(i) * 32'h0101));
    for (int i = 0; i < 8; i++) rchk("R8 storage readback", sto(i), 32'hC0DE_0000 | (32'(i) * 32'h0101));

    // R9 unmapped offsets
    wr(8'hC0, 32'h5);
    wr(8'hD0, 32'h3);
    for (int a = 0; a < 64; a++) begin
      logic [7:0] ad;
      ad = 8'(a * 4);
      if (!mapped(ad)) begin
        wr(ad, 32'hFFFF_FFFF);
        rchk("R9 unmapped reads zero", ad, 32'h0);
      end
    end
    wr(8'hC1, 32'hFFFF_FFFF);
    wr(8'hD2, 32'hFFFF_FFFF);
    rchk("R9 unaligned reads zero", 8'hC1, 32'h0);
    wr(8'hF0, 32'hFFFF_FFFF);
    rchk("R9 level word ignores write", 8'hF0, 32'h0);
    rchk("R9 enable untouched", 8'hC0, 32'h5);
    rchk("R9 pending untouched", 8'hD0, 32'h3);
    chk("R9 irq_out untouched", {31'h0, irq_out}, 32'h1);
    rchk("R9 slot0 untouched", 8'hE0, 32'h43F);
    rchk("R9 slot1 untouched", 8'hE4, 32'h435);
    for (int i = 0; i < 8; i++) rchk("R9 storage untouched", sto(i), 32'hC0DE_0000 | (32'(i) * 32'h0101));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule